// File: doc/BRIEF.md
# Tagged 64-bit FIFO Host Port

This block connects a 32-bit host register bus to a pair of 68-bit FIFOs. Each entry holds 64 data bits and a 4-bit tag. The inbound FIFO is filled by the host and drained by a processing element (PE). The outbound FIFO is filled by the PE and drained by the host. A wide entry crosses the narrow bus in pieces. The upper data word and the tag sit in staging registers. Only the access to the lower word moves an entry into or out of a FIFO.

A host that needs only 32 bits per entry writes or reads the lower word alone, which takes one bus cycle per entry. The inbound tag stays where it was written, so the host rewrites it only when it changes. A loopback input feeds inbound entries straight into the outbound FIFO, one per cycle, for debug.

Each FIFO is 16 entries deep, single-clock, with a synchronous active-high reset. Register addresses (3 bits):

| Address | Register |
|---|---|
| 0 | inbound low word (write-only) |
| 1 | inbound high word (write-only) |
| 2 | inbound tag (write-only) |
| 3 | status (read-only) |
| 4 | outbound low word (read-only) |
| 5 | outbound high word (read-only) |
| 6 | outbound tag (read-only) |
| 7 | unused |

Read data appears on `hostRdData` in the cycle after the read strobe.

Top module: `tagged_fifo_port`

## Requirements
- R1: After reset, both FIFOs are empty and neither is full, the staged high word and tag are zero, and the status register reads 0xA.
- R2: A write to address 1 (high word) or address 2 (tag, bits 3:0) only updates its staging register. It does not push an entry and does not change the status.
- R3: A write to address 0 pushes one entry. The entry holds the written word in data bits 31:0, the staged high word in bits 63:32, and the staged tag. The PE sees the head entry on `peInData`/`peInTag` before it pops.
- R4: The staged high word and tag persist across any number of pushes until they are rewritten.
- R5: After 16 accepted pushes a FIFO reports full, and a further push is dropped without changing its contents. A FIFO is never full and empty at once.
- R6: Entries leave each FIFO in the order they were accepted. A PE pop (`peInPop`) on an empty inbound FIFO has no effect.
- R7: On the outbound side, a read of address 5 or 6 returns the head entry's high word or tag without popping. A read of address 4 returns the head's low word and pops the entry.
- R8: A read of address 4, 5 or 6 while the outbound FIFO is empty leaves `hostRdData` at its previous value and changes no state.
- R9: A read of address 0, 1, 2 or 7 returns zero. A write to address 3, 4, 5, 6 or 7 has no effect.
- R10: Status bits at address 3:
  - bit 0: inbound full
  - bit 1: inbound empty
  - bit 2: outbound full
  - bit 3: outbound empty
  - all other bits read zero
- R11: While `loopbackEn` is high, the head entry of the inbound FIFO moves into the outbound FIFO in each cycle where the inbound FIFO is not empty and the outbound FIFO is not full. In that mode `peInPop` and `peOutPush` are ignored.
- R12: A PE push (`peOutPush`) stores {`peOutTag`, `peOutData`}. If the outbound FIFO is full, the push is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostAddr | input | 3 | Register address |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Host read data, registered |
| loopbackEn | input | 1 | Loopback debug mode |
| peInPop | input | 1 | PE pops the inbound head |
| peInData | output | 64 | Inbound head data |
| peInTag | output | 4 | Inbound head tag |
| peInEmpty | output | 1 | Inbound FIFO empty |
| peOutPush | input | 1 | PE pushes an outbound entry |
| peOutData | input | 64 | Outbound entry data |
| peOutTag | input | 4 | Outbound entry tag |
| peOutFull | output | 1 | Outbound FIFO full |

## Verification
The bench fills each FIFO one entry past its depth. It rotates the staged tag and high word only every fourth push, so a design that pushes on high-word or tag writes, or that clears staging after a push, returns the wrong entries. On the outbound side it reads the high word and tag before the low word. A design that pops on those reads, or shows a non-head entry, gets out of order. The bench also covers three other cases:
- Empty reads must hold the last returned value; a design that returns stale memory instead is caught.
- A design that leaks PE strobes in loopback adds or loses entries.
- A design that decodes write-only or unmapped reads returns non-zero data.

// File: rtl/tagged_fifo_pkg.sv
package tagged_fifo_pkg;
  localparam int WORD_W = 32;
  localparam int TAG_W  = 4;
  localparam int ADDR_W = 3;
  localparam int ENTRY_W = 2 * WORD_W + TAG_W;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_IN_LO   = 3'd0,
    ADDR_IN_HI   = 3'd1,
    ADDR_IN_TAG  = 3'd2,
    ADDR_STATUS  = 3'd3,
    ADDR_OUT_LO  = 3'd4,
    ADDR_OUT_HI  = 3'd5,
    ADDR_OUT_TAG = 3'd6,
    ADDR_NONE    = 3'd7
  } regAddr_e;

  typedef enum logic [2:0] {
    SEL_ZERO,
    SEL_STATUS,
    SEL_OUT_LO,
    SEL_OUT_HI,
    SEL_OUT_TAG
  } rdSel_e;

  typedef struct packed {
    logic   inPush;
    logic   hiWr;
    logic   tagWr;
    logic   rdLoad;
    rdSel_e rdSel;
    logic   outPop;
    logic   loopMove;
  } hostStrobe_t;
endpackage

// File: rtl/tagged_fifo_mem.sv
module tagged_fifo_mem #(
  parameter int WIDTH = 68,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;
  logic             doPush, doPop;

  assign full   = (count == CNT_W'(DEPTH));
  assign empty  = (count == '0);
  assign doPush = push && !full;
  assign doPop  = pop && !empty;
  assign head   = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/tagged_fifo_ctrl.sv
module tagged_fifo_ctrl
  import tagged_fifo_pkg::*;
(
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              loopbackEn,
  input  logic              inEmpty,
  input  logic              outFull,
  input  logic              outEmpty,
  output hostStrobe_t       strobe
);
  logic outSideRead;

  always_comb begin
    strobe = '0;
    strobe.rdSel = SEL_ZERO;
    outSideRead = 1'b0;
    if (hostWr) begin
      case (hostAddr)
        ADDR_IN_LO:  strobe.inPush = 1'b1;
        ADDR_IN_HI:  strobe.hiWr   = 1'b1;
        ADDR_IN_TAG: strobe.tagWr  = 1'b1;
        default:     ;
      endcase
    end
    case (hostAddr)
      ADDR_STATUS:  strobe.rdSel = SEL_STATUS;
      ADDR_OUT_LO:  begin strobe.rdSel = SEL_OUT_LO;  outSideRead = 1'b1; end
      ADDR_OUT_HI:  begin strobe.rdSel = SEL_OUT_HI;  outSideRead = 1'b1; end
      ADDR_OUT_TAG: begin strobe.rdSel = SEL_OUT_TAG; outSideRead = 1'b1; end
      default:      strobe.rdSel = SEL_ZERO;
    endcase
    strobe.rdLoad   = hostRd && !(outSideRead && outEmpty);
    strobe.outPop   = hostRd && (hostAddr == ADDR_OUT_LO) && !outEmpty;
    strobe.loopMove = loopbackEn && !inEmpty && !outFull;
  end
endmodule

// File: rtl/tagged_fifo_dp.sv
module tagged_fifo_dp
  import tagged_fifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  hostStrobe_t         strobe,
  input  logic [WORD_W-1:0]   hostWrData,
  output logic [WORD_W-1:0]   hostRdData,
  input  logic                loopbackEn,
  input  logic                peInPop,
  output logic [2*WORD_W-1:0] peInData,
  output logic [TAG_W-1:0]    peInTag,
  input  logic                peOutPush,
  input  logic [2*WORD_W-1:0] peOutData,
  input  logic [TAG_W-1:0]    peOutTag,
  output logic                inFull,
  output logic                inEmpty,
  output logic                outFull,
  output logic                outEmpty
);
  logic [WORD_W-1:0]  stagedHi;
  logic [TAG_W-1:0]   stagedTag;
  logic [ENTRY_W-1:0] inHead, outHead, outPushData;
  logic               inPopSel, outPushSel;
  logic [WORD_W-1:0]  rdNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      stagedHi  <= '0;
      stagedTag <= '0;
    end else begin
      if (strobe.hiWr)  stagedHi  <= hostWrData;
      if (strobe.tagWr) stagedTag <= hostWrData[TAG_W-1:0];
    end
  end

  assign inPopSel    = loopbackEn ? strobe.loopMove : peInPop;
  assign outPushSel  = loopbackEn ? strobe.loopMove : peOutPush;
  assign outPushData = loopbackEn ? inHead : {peOutTag, peOutData};

  tagged_fifo_mem #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) inFifo_i (
    .clk(clk), .rst(rst),
    .push(strobe.inPush), .pushData({stagedTag, stagedHi, hostWrData}),
    .pop(inPopSel), .head(inHead), .full(inFull), .empty(inEmpty)
  );

  tagged_fifo_mem #(.WIDTH(ENTRY_W), .DEPTH(DEPTH)) outFifo_i (
    .clk(clk), .rst(rst),
    .push(outPushSel), .pushData(outPushData),
    .pop(strobe.outPop), .head(outHead), .full(outFull), .empty(outEmpty)
  );

  assign peInData = inHead[2*WORD_W-1:0];
  assign peInTag  = inHead[ENTRY_W-1 -: TAG_W];

  always_comb begin
    rdNext = '0;
    case (strobe.rdSel)
      SEL_STATUS:  rdNext[3:0] = {outEmpty, outFull, inEmpty, inFull};
      SEL_OUT_LO:  rdNext = outHead[WORD_W-1:0];
      SEL_OUT_HI:  rdNext = outHead[2*WORD_W-1:WORD_W];
      SEL_OUT_TAG: rdNext[TAG_W-1:0] = outHead[ENTRY_W-1 -: TAG_W];
      default:     rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                hostRdData <= '0;
    else if (strobe.rdLoad) hostRdData <= rdNext;
  end
endmodule

// File: rtl/tagged_fifo_port.sv
module tagged_fifo_port
  import tagged_fifo_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hostWr,
  input  logic          hostRd,
  input  logic [2:0]    hostAddr,
  input  logic [31:0]   hostWrData,
  output logic [31:0]   hostRdData,
  input  logic          loopbackEn,
  input  logic          peInPop,
  output logic [63:0]   peInData,
  output logic [3:0]    peInTag,
  output logic          peInEmpty,
  input  logic          peOutPush,
  input  logic [63:0]   peOutData,
  input  logic [3:0]    peOutTag,
  output logic          peOutFull
);
  hostStrobe_t strobe;
  logic inFull, inEmpty, outFull, outEmpty;

  tagged_fifo_ctrl ctrl_i (
    .hostWr(hostWr), .hostRd(hostRd), .hostAddr(hostAddr),
    .loopbackEn(loopbackEn), .inEmpty(inEmpty), .outFull(outFull),
    .outEmpty(outEmpty), .strobe(strobe)
  );

  tagged_fifo_dp #(.DEPTH(DEPTH)) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .loopbackEn(loopbackEn), .peInPop(peInPop),
    .peInData(peInData), .peInTag(peInTag),
    .peOutPush(peOutPush), .peOutData(peOutData), .peOutTag(peOutTag),
    .inFull(inFull), .inEmpty(inEmpty), .outFull(outFull), .outEmpty(outEmpty)
  );

  assign peInEmpty = inEmpty;
  assign peOutFull = outFull;
endmodule

// File: rtl/tagged_fifo_port_chk.sv
module tagged_fifo_port_chk (
  input logic        clk,
  input logic        rst,
  input logic        hostRd,
  input logic [2:0]  hostAddr,
  input logic [31:0] hostRdData,
  input logic        loopbackEn,
  input logic        inFull,
  input logic        inEmpty,
  input logic        outFull,
  input logic        outEmpty
);
  assert_flags_exclusive_R5: assert property (@(posedge clk) disable iff (rst)
    !(inFull && inEmpty) && !(outFull && outEmpty));

  assert_full_not_drained_R5: assert property (@(posedge clk) disable iff (rst)
    inFull |=> !inEmpty);

  assert_empty_read_holds_R8: assert property (@(posedge clk) disable iff (rst)
    hostRd && (hostAddr >= 3'd4) && (hostAddr <= 3'd6) && outEmpty |=> $stable(hostRdData));

  assert_wo_read_zero_R9: assert property (@(posedge clk) disable iff (rst)
    hostRd && ((hostAddr <= 3'd2) || (hostAddr == 3'd7)) |=> (hostRdData == 32'd0));

  assert_loop_moves_R11: assert property (@(posedge clk) disable iff (rst)
    loopbackEn && !inEmpty && !outFull |=> !outEmpty);
endmodule

bind tagged_fifo_port tagged_fifo_port_chk chk_i (
  .clk(clk), .rst(rst), .hostRd(hostRd), .hostAddr(hostAddr),
  .hostRdData(hostRdData), .loopbackEn(loopbackEn),
  .inFull(inFull), .inEmpty(inEmpty), .outFull(outFull), .outEmpty(outEmpty)
);

// File: tb/tagged_fifo_port_tb.sv
module tagged_fifo_port_tb_top;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hostWr = 1'b0, hostRd = 1'b0;
  logic [2:0]  hostAddr = '0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic        loopbackEn = 1'b0, peInPop = 1'b0, peOutPush = 1'b0;
  logic [63:0] peInData, peOutData = '0;
  logic [3:0]  peInTag, peOutTag = '0;
  logic        peInEmpty, peOutFull;

  int errors = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  tagged_fifo_port #(.DEPTH(DEPTH)) dut_i (.*);

  task automatic check(input bit ok, input string req, input logic [67:0] act, input logic [67:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); hostWr = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk); hostWr = 1'b0;
  endtask

  task automatic hostRead(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); hostRd = 1'b1; hostAddr = a;
    @(negedge clk); hostRd = 1'b0; d = hostRdData;
  endtask

  function automatic logic [31:0] loVal(int i); return 32'hA5000000 + i * 32'h01010101; endfunction
  function automatic logic [31:0] hiVal(int i); return ~(32'h3C00_0000 + i * 32'h00110011); endfunction

  logic [67:0] expQ [DEPTH];

  initial begin
    logic [31:0] rd;
    logic [31:0] curHi;
    logic [3:0]  curTag;
    int accepted;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    hostRead(3'd3, rd);
    check(rd == 32'hA, "R1 status after reset", rd, 32'hA);
    check(peInEmpty && !peOutFull, "R1 pe flags", {peInEmpty, peOutFull}, 2'b10);

    hostWrite(3'd1, 32'h12345678);
    hostWrite(3'd2, 32'hFFFF_FFF9);
    hostRead(3'd3, rd);
    check(rd == 32'hA && peInEmpty, "R2 staging writes do not push", rd, 32'hA);

    // Fill inbound one past depth; staging rotates every 4th push
    curHi = 32'h12345678; curTag = 4'h9; accepted = 0;
    for (int i = 0; i <= DEPTH; i++) begin
      if (i % 4 == 3) begin
        curHi = hiVal(i); curTag = 4'(i * 5);
        hostWrite(3'd1, curHi);
        hostWrite(3'd2, {28'hABCDEF0, curTag});
      end
      hostWrite(3'd0, loVal(i));
      if (accepted < DEPTH) begin
        expQ[accepted] = {curTag, curHi, loVal(i)};
        accepted++;
      end
    end
    hostRead(3'd3, rd);
    check(rd == 32'h9, "R5 R10 inbound full status", rd, 32'h9);

    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      check({peInTag, peInData} == expQ[i], "R3 R4 R6 inbound entry", {peInTag, peInData}, expQ[i]);
      peInPop = 1'b1;
      @(negedge clk); peInPop = 1'b0;
    end
    check(peInEmpty, "R5 overflow push dropped", peInEmpty, 1);
    @(negedge clk); peInPop = 1'b1;
    @(negedge clk); peInPop = 1'b0;
    hostRead(3'd3, rd);
    check(rd == 32'hA, "R6 pop on empty no effect", rd, 32'hA);

    // write-only and unmapped reads
    for (int a = 0; a < 8; a++) begin
      if (a <= 2 || a == 7) begin
        hostRead(3'(a), rd);
        check(rd == 0, "R9 write-only or unmapped read is zero", rd, 0);
      end
    end
    // writes to read-only addresses
    for (int a = 3; a < 8; a++) hostWrite(3'(a), 32'hDEAD0000 + a);
    hostRead(3'd3, rd);
    check(rd == 32'hA && !peOutFull, "R9 read-only writes ignored", rd, 32'hA);
    // empty outbound reads hold last value (0xA)
    for (int a = 4; a <= 6; a++) begin
      hostRead(3'(a), rd);
      check(rd == 32'hA, "R8 empty read holds", rd, 32'hA);
    end

    // Outbound path: PE fills one past depth
    for (int i = 0; i <= DEPTH; i++) begin
      @(negedge clk);
      peOutPush = 1'b1; peOutData = {hiVal(i + 40), loVal(i + 40)}; peOutTag = 4'(15 - i);
      if (i < DEPTH) expQ[i] = {4'(15 - i), hiVal(i + 40), loVal(i + 40)};
      @(negedge clk); peOutPush = 1'b0;
    end
    check(peOutFull, "R12 outbound full", peOutFull, 1);
    hostRead(3'd3, rd);
    check(rd == 32'h6, "R10 outbound full status", rd, 32'h6);
    for (int i = 0; i < DEPTH; i++) begin
      logic [31:0] h, t, l;
      hostRead(3'd5, h);
      hostRead(3'd6, t);
      hostRead(3'd4, l);
      check({t[3:0], h, l} == expQ[i] && t[31:4] == 0, "R7 R12 outbound entry", {t[3:0], h, l}, expQ[i]);
    end
    hostRead(3'd3, rd);
    check(rd == 32'hA, "R7 drained", rd, 32'hA);

    // Loopback with stray PE strobes
    loopbackEn = 1'b1;
    hostWrite(3'd1, 32'h0BADF00D);
    hostWrite(3'd2, 32'h3);
    for (int i = 0; i < 6; i++) begin
      expQ[i] = {4'h3, 32'h0BADF00D, loVal(i + 90)};
      hostWrite(3'd0, loVal(i + 90));
      @(negedge clk); peInPop = 1'b1; peOutPush = 1'b1; peOutData = '1; peOutTag = 4'hF;
      @(negedge clk); peInPop = 1'b0; peOutPush = 1'b0;
    end
    repeat (2) @(negedge clk);
    check(peInEmpty, "R11 inbound drained by loopback", peInEmpty, 1);
    for (int i = 0; i < 6; i++) begin
      logic [31:0] h, t, l;
      hostRead(3'd5, h);
      hostRead(3'd6, t);
      hostRead(3'd4, l);
      check({t[3:0], h, l} == expQ[i], "R11 loopback entry", {t[3:0], h, l}, expQ[i]);
    end
    hostRead(3'd3, rd);
    check(rd == 32'hA, "R11 no stray entries", rd, 32'hA);
    loopbackEn = 1'b0;

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule